// File: doc/BRIEF.md
# UART Modem-Line Flow Control Unit

This block applies hardware flow control for a UART that has a 128-byte receive FIFO. In the receive direction it compares the FIFO fill level against a programmable 7-bit limit. It drives an active-low request-to-send line high to hold off the peer once the fill level rises above that limit. In the transmit direction it samples the peer's clear-to-send line through a synchronizer. From it, the block produces a permit that the transmitter consults before starting each new character.

Each direction has its own enable. With receive control disabled, the request line always invites the peer to send. With transmit control disabled, the permit ignores the clear-to-send line. A character that is already being shifted out is never cut short: the permit is frozen while the transmitter reports it is busy. The permit changes only at character boundaries.

Top module: `uart_flowctl`

## Requirements
- R1: While reset is low, and on the cycle after it is sampled low, `rts_n` is 1 (peer held off) and `tx_permit` is 0.
- R2: When `rx_flow_en` is 0, `rts_n` is 0 on the cycle after the clock edge that samples it, whatever the fill level.
- R3: When `rx_flow_en` is 1 and `rx_level` is strictly greater than `rx_thresh`, `rts_n` is 1 one clock edge later.
- R4: When `rx_flow_en` is 1 and `rx_level` is less than or equal to `rx_thresh`, `rts_n` is 0 one clock edge later, including at equality.
- R5: The limit works over its whole range 0 to 127. A limit of 0 holds off at level 1, and a limit of 127 holds off only at level 128.
- R6: When `tx_flow_en` is 0 and the transmitter is idle, `tx_permit` is 1 one clock edge later, whatever the level on `cts_n`.
- R7: `cts_n` passes through two synchronizing flops. With `tx_flow_en` 1 and the transmitter idle, a level on `cts_n` is reflected in `tx_permit` three edges after it is first sampled: 1 on `cts_n` gives permit 0, and 0 gives permit 1.
- R8: While `tx_busy` is 1, `tx_permit` does not change, so a character in flight always finishes.
- R9: When `tx_busy` returns to 0, `tx_permit` takes the value set by the current synchronized `cts_n` and the enable on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 8 | Current receive FIFO fill level, 0 to 128 |
| rx_flow_en | input | 1 | Enable for receive-side flow control |
| rx_thresh | input | 7 | Fill level above which the peer is held off |
| cts_n | input | 1 | Peer clear-to-send, asynchronous, 1 means halt |
| tx_flow_en | input | 1 | Enable for transmit-side flow control |
| tx_busy | input | 1 | Transmitter is shifting a character |
| rts_n | output | 1 | Request-to-send to the peer, 1 means stop sending |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
A wrong threshold comparison shows on `rts_n` one edge after the fill level crosses the limit, so the equality and end-of-range cases expose an off-by-one at once. A synchronizer with the wrong depth moves the `tx_permit` transition one edge early or late relative to the `cts_n` change. A permit register that is not frozen during `tx_busy` toggles in the middle of a character, and this is visible on the first cycle of the change. The bench compares both outputs against a behavioural model on every cycle, so any of these faults appears within a few cycles of the stimulus that provokes it.

// File: rtl/uart_flowctl_pkg.sv
// Package: shared constants for the UART flow control unit.
// Assumes: line polarities are fixed active-low for both modem lines.
package uart_flowctl_pkg;
    localparam logic FC_LINE_STOP  = 1'b1;  // level that means "stop sending"
    localparam logic FC_LINE_GO    = 1'b0;  // level that means "free to send"
    localparam int   FC_FIFO_DEPTH = 128;   // receive FIFO capacity in bytes
endpackage

// File: rtl/uart_fc_sync.sv
// Module: uart_fc_sync
// Multi-stage synchronizer for an asynchronous line level.
// Assumes: the input is a slow level; the reset value is the safe "stop" level.
module uart_fc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], d_async};
    end

    assign q_sync = stage_q[STAGES-1];

    // R7: the output follows the stage before it by exactly one edge.
    p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_sync == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/uart_fc_rx_gate.sv
// Module: uart_fc_rx_gate
// Drives the active-low request-to-send line from the receive FIFO fill level.
// Assumes: level never exceeds the FIFO depth; the threshold is zero-extended.
module uart_fc_rx_gate
    import uart_flowctl_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             enable,
    input  logic [THR_W-1:0] thresh,
    output logic             rts_n
);
    localparam int PAD_W = LVL_W - THR_W;

    logic [LVL_W-1:0] limit_ext;
    logic             over_limit;

    // Widen the threshold to the level width for an unsigned compare.
    assign limit_ext  = {{PAD_W{1'b0}}, thresh};
    assign over_limit = (level > limit_ext);

    // Register the request line: stop only when enabled and over the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rts_n <= FC_LINE_STOP;
        else if (enable && over_limit) rts_n <= FC_LINE_STOP;
        else                           rts_n <= FC_LINE_GO;
    end

    // R2: disabling receive control releases the line on the next edge.
    p_release_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rts_n == FC_LINE_GO));
    // R3: a rising stop is only ever caused by an over-limit fill level.
    p_stop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> ($past(level) > {{PAD_W{1'b0}}, $past(thresh)}));
    // R4: a release happens only when disabled or at or below the limit.
    p_release_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n) |-> (!$past(enable) || ($past(level) <= {{PAD_W{1'b0}}, $past(thresh)})));
    // R5: the level input stays within the FIFO capacity.
    p_level_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= FC_FIFO_DEPTH);
endmodule

// File: rtl/uart_fc_tx_gate.sv
// Module: uart_fc_tx_gate
// Produces the transmit permit from the synchronized clear-to-send level.
// Assumes: tx_busy is high for the whole character the transmitter shifts out.
module uart_fc_tx_gate
    import uart_flowctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_sync,
    input  logic enable,
    input  logic busy,
    output logic permit
);
    logic next_permit;

    // Permit is granted when control is off or the peer signals go.
    assign next_permit = !enable || (cts_sync == FC_LINE_GO);

    // Update the permit only at a character boundary (transmitter idle).
    always_ff @(posedge clk) begin
        if (!rst_n)     permit <= 1'b0;
        else if (!busy) permit <= next_permit;
    end

    // R8: the permit is frozen while a character is in flight.
    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(permit));
    // R9: any change of permit happens after an idle cycle.
    p_change_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(permit) |-> !$past(busy));
    // R6: with control off and idle, permit is granted on the next edge.
    p_grant_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !busy) |=> permit);
endmodule

// File: rtl/uart_flowctl.sv
// Module: uart_flowctl (top)
// Hardware flow control for a UART: request-to-send from receive FIFO
// occupancy, and a per-character transmit permit from clear-to-send.
// Assumes: synchronous inputs except cts_n, which is synchronized here.
module uart_flowctl
    import uart_flowctl_pkg::*;
#(
    parameter int FIFO_DEPTH  = FC_FIFO_DEPTH,
    parameter int THR_W       = 7,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_flow_en,
    input  logic [THR_W-1:0] rx_thresh,
    input  logic             cts_n,
    input  logic             tx_flow_en,
    input  logic             tx_busy,
    output logic             rts_n,
    output logic             tx_permit
);
    logic cts_s;

    // Receive direction: occupancy against threshold.
    uart_fc_rx_gate #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rx_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (rx_level),
        .enable (rx_flow_en),
        .thresh (rx_thresh),
        .rts_n  (rts_n)
    );

    // Bring the peer's clear-to-send into the clock domain.
    uart_fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(FC_LINE_STOP)) u_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_n),
        .q_sync  (cts_s)
    );

    // Transmit direction: per-character permit.
    uart_fc_tx_gate u_tx_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_sync (cts_s),
        .enable   (tx_flow_en),
        .busy     (tx_busy),
        .permit   (tx_permit)
    );

    // R1: one edge of reset leaves the peer held off and no permit.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (rts_n && !tx_permit));
endmodule

// File: tb/uart_flowctl_bench.sv
module uart_flowctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_level = '0;
    logic       rx_flow_en = 1'b0;
    logic [6:0] rx_thresh = '0;
    logic       cts_n = 1'b1;
    logic       tx_flow_en = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rts_n;
    logic       tx_permit;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase = "R1";

    // behavioural model state
    int  cts_hist[$];
    bit  m_rts = 1'b1;
    bit  m_permit = 1'b0;

    always #5 clk = ~clk;

    uart_flowctl u_uart_flowctl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_flow_en(rx_flow_en),
        .rx_thresh(rx_thresh), .cts_n(cts_n), .tx_flow_en(tx_flow_en),
        .tx_busy(tx_busy), .rts_n(rts_n), .tx_permit(tx_permit)
    );

    initial begin
        cts_hist = '{1, 1};
    end

    // Reference model advanced on every rising edge.
    always @(posedge clk) begin
        int oldest;
        if (!rst_n) begin
            cts_hist = '{1, 1};
            m_rts = 1'b1;
            m_permit = 1'b0;
        end else begin
            oldest = cts_hist[0];
            m_rts = rx_flow_en && (int'(rx_level) > int'(rx_thresh));
            if (!tx_busy) m_permit = !tx_flow_en || (oldest == 0);
            void'(cts_hist.pop_front());
            cts_hist.push_back(int'(cts_n));
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (rts_n !== m_rts || tx_permit !== m_permit) begin
                mismatched++;
                $display("FAIL %s: rts_n=%b tx_permit=%b expected rts_n=%b tx_permit=%b at %0t",
                         phase, rts_n, tx_permit, m_rts, m_permit, $time);
            end
        end
    end

    task automatic check(input bit got, input bit exp, input string tag);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive_slot();
        @(posedge clk); #2;
    endtask

    task automatic settle(input int edges);
        repeat (edges) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        phase = "R1";
        settle(3);
        check(rts_n, 1'b1, "R1 rts_n");
        check(tx_permit, 1'b0, "R1 tx_permit");
        drive_slot(); rst_n = 1'b1;

        // R2: disabled receive control ignores a full FIFO
        phase = "R2";
        rx_level = 8'd128; rx_thresh = 7'd5;
        settle(1);
        check(rts_n, 1'b0, "R2 disabled full");

        // R3/R4: threshold 10
        phase = "R3_R4";
        drive_slot(); rx_flow_en = 1'b1; rx_thresh = 7'd10; rx_level = 8'd10;
        settle(1);
        check(rts_n, 1'b0, "R4 equal level");
        drive_slot(); rx_level = 8'd11;
        settle(1);
        check(rts_n, 1'b1, "R3 above limit");
        drive_slot(); rx_level = 8'd10;
        settle(1);
        check(rts_n, 1'b0, "R4 back to equal");

        // R5: range ends
        phase = "R5";
        drive_slot(); rx_thresh = 7'd0; rx_level = 8'd0;
        settle(1);
        check(rts_n, 1'b0, "R5 thr0 lvl0");
        drive_slot(); rx_level = 8'd1;
        settle(1);
        check(rts_n, 1'b1, "R5 thr0 lvl1");
        drive_slot(); rx_thresh = 7'd127; rx_level = 8'd127;
        settle(1);
        check(rts_n, 1'b0, "R5 thr127 lvl127");
        drive_slot(); rx_level = 8'd128;
        settle(1);
        check(rts_n, 1'b1, "R5 thr127 lvl128");

        // R2: clearing enable releases next cycle
        phase = "R2";
        drive_slot(); rx_flow_en = 1'b0;
        settle(1);
        check(rts_n, 1'b0, "R2 release on disable");

        // R6: tx control off ignores CTS halt
        phase = "R6";
        drive_slot(); cts_n = 1'b1; tx_flow_en = 1'b0;
        settle(1);
        check(tx_permit, 1'b1, "R6 off ignores cts");
        settle(3);
        check(tx_permit, 1'b1, "R6 still permitted");

        // R7: synchronizer latency with control on
        phase = "R7";
        drive_slot(); cts_n = 1'b0; tx_flow_en = 1'b1;
        settle(4);
        check(tx_permit, 1'b1, "R7 go level");
        drive_slot(); cts_n = 1'b1;
        settle(2);
        check(tx_permit, 1'b1, "R7 not yet after two edges");
        settle(1);
        check(tx_permit, 1'b0, "R7 halt on third edge");

        // R8: busy freezes permit at 0 while CTS goes low
        phase = "R8";
        drive_slot(); tx_busy = 1'b1; cts_n = 1'b0;
        settle(5);
        check(tx_permit, 1'b0, "R8 frozen low while busy");

        // R9: boundary update
        phase = "R9";
        drive_slot(); tx_busy = 1'b0;
        settle(1);
        check(tx_permit, 1'b1, "R9 update at boundary");

        // R8: character in flight finishes despite halt
        phase = "R8";
        drive_slot(); tx_busy = 1'b1; cts_n = 1'b1;
        settle(5);
        check(tx_permit, 1'b1, "R8 frozen high while busy");
        drive_slot(); tx_busy = 1'b0;
        settle(1);
        check(tx_permit, 1'b0, "R9 halt applied at boundary");

        // mixed pattern sweep under model comparison
        phase = "R3_R4_sweep";
        drive_slot(); rx_flow_en = 1'b1; rx_thresh = 7'd64;
        for (int lv = 60; lv <= 70; lv++) begin
            drive_slot(); rx_level = 8'(lv); tx_busy = lv[0]; cts_n = lv[1];
        end
        settle(4);
        finish_run();
    end
endmodule